// File: doc/BRIEF.md
# Staged-Commit I2C Command Register Target

This block is an I2C target that owns a small bank of 8-bit command registers and answers reads with one byte of status. A bus master writes a register by sending the device's write address, then a pointer, then the data byte. The data byte does not reach the command outputs at once. It is parked in a holding latch for that pointer. All holding latches are copied into the command registers together when a STOP condition appears on the bus. A master can therefore load several registers, and also talk to other devices through repeated STARTs, and then make every change take effect at the same instant with one STOP.

SCL and SDA are oversampled by the system clock through two-flop synchronizers. SDA is open-drain, so the block only tells the pad when to pull the line low. A synchronous clear input zeroes both the holding latches and the command registers. It stands in for a supply fault or a power-down event.

Top module: `i2c_cmd_target`

## Requirements
- R1: The 7-bit device address is 0b0001001, so the address byte is 0x12 for a write and 0x13 for a read (LSB = 1 means read), and both are acknowledged. Any other address byte is not acknowledged, and every later byte is ignored and not acknowledged until the next START or STOP.
- R2: A write consists of the address byte, then a pointer byte, then a data byte, each sent MSB first. The target acknowledges each one by pulling SDA low while SCL is high in the ninth clock.
- R3: Only the low two bits of the pointer select the register, so pointer 0x06 reaches register 2 and pointer 0x07 reaches register 3.
- R4: The data byte is stored in the holding latch for its pointer in the same cycle in which the target begins its acknowledge. The command outputs do not change at that point.
- R5: A STOP (SDA rising while SCL is high) copies every holding latch into its command register in a single cycle.
- R6: Holding latches keep their contents across repeated STARTs, including transfers addressed to other devices. One final STOP commits all staged writes.
- R7: After it acknowledges 0x13, the target sends the status input, MSB first, one bit per SCL clock. The status is captured when the address acknowledge ends, so later changes on the input do not alter the byte being sent.
- R8: Whether the master acknowledges the status byte or not has no effect on any register. A read needs no STOP, and a START that follows a read begins a new transfer normally.
- R9: Reset, and also the clear input, set every holding latch and every command register to zero. A write staged before a clear is not committed by a later STOP.
- R10: The target changes its SDA drive only while SCL is low.
- R11: The command outputs change only on a STOP commit, on clear or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of holding latches and command registers |
| scl_in | input | 1 | SCL level from the pad |
| sda_in | input | 1 | SDA level from the pad |
| status_in | input | 8 | Status byte returned on reads |
| sda_oe | output | 1 | High when the target pulls SDA low |
| cmd_q | output | 4x8 | Command registers, element i is register i |

## Verification
On every cycle the assertions check three things. The SDA drive never moves while synchronized SCL stays high. A stored data byte is followed by an acknowledge. The command outputs hold still unless a STOP or a clear occurs, and they match the holding latches after a commit. The assertions also check that a clear leaves all outputs at zero. Other behaviour can only be shown by the bench scenarios: the address matching, the pointer aliasing, and the deferral of several writes across repeated STARTs to a foreign device. The same holds for the MSB-first status byte being stable against input changes, for reads that end without a STOP, and for a clear discarding staged data.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_SUB,
        ST_ACK_S,
        ST_DATA,
        ST_ACK_D,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync
    import i2c_cmd_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int PW = SYNC + 1;

    logic [PW-1:0] scl_p;
    logic [PW-1:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[PW-2:0], scl_in};
            sda_p <= {sda_p[PW-2:0], sda_in};
        end
    end

    logic scl_s, scl_d, sda_s, sda_d;
    assign scl_s = scl_p[SYNC-1];
    assign scl_d = scl_p[SYNC];
    assign sda_s = sda_p[SYNC-1];
    assign sda_d = sda_p[SYNC];

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.start = scl_s && scl_d && sda_d && !sda_s;
        ev.stop  = scl_s && scl_d && !sda_d && sda_s;
        ev.rise  = scl_s && !scl_d;
        ev.fall  = !scl_s && scl_d;
    end
endmodule

// File: rtl/i2c_cmd_fsm.sv
module i2c_cmd_fsm
    import i2c_cmd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h09,
    parameter int         NREG     = 4,
    parameter int         DW       = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_ev_t              ev,
    input  logic [DW-1:0]        status_in,
    output logic                 sda_oe,
    output logic                 wr_en,
    output logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] wr_idx,
    output logic [DW-1:0]        wr_data,
    output logic                 commit
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int CNT_W = $clog2(DW + 1);

    tgt_state_e        state;
    logic [CNT_W-1:0]  bitcnt;
    logic [DW-1:0]     shreg;
    logic [DW-1:0]     txsr;
    logic [IDX_W-1:0]  ptr;
    logic              rw;
    logic              byte_done;

    assign byte_done = ev.fall && (bitcnt == CNT_W'(DW));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            txsr   <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
        end else begin
            case (state)
                ST_ADDR, ST_SUB, ST_DATA: begin
                    if (ev.rise && bitcnt < CNT_W'(DW)) begin
                        shreg  <= {shreg[DW-2:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            rw    <= shreg[0];
                            state <= addr_hit(shreg, DEV_ADDR) ? ST_ACK_A : ST_SKIP;
                        end else if (state == ST_SUB) begin
                            ptr   <= shreg[IDX_W-1:0];
                            state <= ST_ACK_S;
                        end else begin
                            state <= ST_ACK_D;
                        end
                    end
                end
                ST_ACK_A: if (ev.fall) begin
                    if (rw) begin
                        txsr   <= status_in;
                        bitcnt <= '0;
                        state  <= ST_RD;
                    end else begin
                        state  <= ST_SUB;
                    end
                end
                ST_ACK_S: if (ev.fall) state <= ST_DATA;
                ST_ACK_D: if (ev.fall) state <= ST_SKIP;
                ST_RD: if (ev.fall) begin
                    if (bitcnt == CNT_W'(DW - 1)) begin
                        state <= ST_RD_ACK;
                    end else begin
                        txsr   <= {txsr[DW-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_RD_ACK: if (ev.fall) state <= ST_SKIP;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_ACK_A, ST_ACK_S, ST_ACK_D: sda_oe = 1'b1;
            ST_RD:                        sda_oe = ~txsr[DW-1];
            default:                      sda_oe = 1'b0;
        endcase
    end

    assign wr_en   = (state == ST_DATA) && byte_done && !ev.start && !ev.stop;
    assign wr_idx  = ptr;
    assign wr_data = shreg;
    assign commit  = ev.stop;

    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl)) |-> $stable(sda_oe)) else $error("sda drive moved with SCL high"); // R10

    AST_WRITE_THEN_ACK: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> sda_oe) else $error("stored byte not acknowledged"); // R4
endmodule

// File: rtl/i2c_cmd_regbank.sv
module i2c_cmd_regbank #(
    parameter int NREG = 4,
    parameter int DW   = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] wr_idx,
    input  logic [DW-1:0]        wr_data,
    input  logic                 commit,
    output logic [NREG-1:0][DW-1:0] cmd_q
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [DW-1:0] hold [NREG];
    logic [DW-1:0] cmd  [NREG];
    logic [NREG-1:0][DW-1:0] hold_v;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                hold[g] <= '0;
                cmd[g]  <= '0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(g)) hold[g] <= wr_data;
                if (commit)                       cmd[g]  <= hold[g];
            end
        end
        assign cmd_q[g]  = cmd[g];
        assign hold_v[g] = hold[g];
    end

    AST_CMD_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (!commit && !clr) |=> $stable(cmd_q)) else $error("command moved without STOP"); // R11

    AST_COMMIT_MATCHES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (commit && !clr && !wr_en) |=> (cmd_q == hold_v)) else $error("commit mismatch"); // R5

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cmd_q == '0 && hold_v == '0)) else $error("clear left data"); // R9
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
    import i2c_cmd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h09,
    parameter int         NREG     = 4,
    parameter int         DW       = 8,
    parameter int         SYNC     = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    scl_in,
    input  logic                    sda_in,
    input  logic [DW-1:0]           status_in,
    output logic                    sda_oe,
    output logic [NREG-1:0][DW-1:0] cmd_q
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    bus_ev_t          ev;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [DW-1:0]    wr_data;
    logic             commit;

    i2c_bus_sync #(.SYNC(SYNC)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_cmd_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .status_in (status_in),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .commit    (commit)
    );

    i2c_cmd_regbank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .commit  (commit),
        .cmd_q   (cmd_q)
    );
endmodule

// File: tb/sim_i2c_cmd_target.sv
module sim_i2c_cmd_target;
    localparam int QC = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [7:0] status_in = 8'h00;
    logic sda_oe;
    logic [3:0][7:0] cmd_q;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_cmd_target u0 (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .status_in (status_in),
        .sda_oe    (sda_oe),
        .cmd_q     (cmd_q)
    );

    int checks = 0;
    int errors = 0;
    int r10_viol = 0;
    bit done = 1'b0;

    string       q_req[$];
    logic [31:0] q_exp[$];
    logic [31:0] q_act[$];

    task automatic push_check(input string req, input logic [31:0] act, input logic [31:0] exp);
        q_req.push_back(req);
        q_exp.push_back(exp);
        q_act.push_back(act);
    endtask

    always @(negedge clk) begin
        while (q_exp.size() > 0) begin
            string       r;
            logic [31:0] e, a;
            r = q_req.pop_front();
            e = q_exp.pop_front();
            a = q_act.pop_front();
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", r, a, e);
            end
        end
    end

    logic prev_scl = 1'b1;
    logic prev_oe  = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_m && prev_scl && sda_oe !== prev_oe) r10_viol++;
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic q();
        repeat (QC) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        sda_m = 1'b0; q();
        scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q();
        scl_m = 1'b1; q();
        sda_m = 1'b1; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q();
            scl_m = 1'b1; q(); q();
            scl_m = 1'b0; q();
        end
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        ack = ~sda_line;
        q();
        scl_m = 1'b0; q();
    endtask

    task automatic read_byte(input logic m_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q();
            scl_m = 1'b1; q();
            b[i] = sda_line;
            q();
            scl_m = 1'b0;
        end
        q();
        sda_m = m_ack ? 1'b0 : 1'b1; q();
        scl_m = 1'b1; q(); q();
        scl_m = 1'b0; q();
        sda_m = 1'b1;
    endtask

    task automatic wr_group(input logic [7:0] ptr, input logic [7:0] data);
        logic a;
        send_byte(8'h12, a); push_check("R2 write address ack", {31'd0, a}, 32'd1);
        send_byte(ptr, a);   push_check("R2 pointer ack",       {31'd0, a}, 32'd1);
        send_byte(data, a);  push_check("R2 data ack",          {31'd0, a}, 32'd1);
    endtask

    initial begin
        logic       a;
        logic [7:0] rb;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        q();
        push_check("R9 reset state", cmd_q, 32'h0);

        // single write, deferred until STOP
        bus_start();
        wr_group(8'h00, 8'hA5);
        q();
        push_check("R4 no change before STOP", cmd_q, 32'h0);
        bus_stop(); q();
        push_check("R5 commit on STOP", cmd_q, 32'h0000_00A5);

        // staged writes across a foreign device transfer
        bus_start();
        wr_group(8'h01, 8'h3C);
        bus_start();
        send_byte(8'hA0, a); push_check("R1 foreign address not acked", {31'd0, a}, 32'd0);
        send_byte(8'h01, a); push_check("R1 ignored after mismatch",    {31'd0, a}, 32'd0);
        send_byte(8'hFF, a); push_check("R1 ignored after mismatch",    {31'd0, a}, 32'd0);
        bus_start();
        wr_group(8'h06, 8'h99);
        push_check("R6 outputs held across repeated START", cmd_q, 32'h0000_00A5);
        push_check("R11 outputs held before STOP", cmd_q, 32'h0000_00A5);
        bus_stop(); q();
        push_check("R6 joint commit with R3 alias", cmd_q, 32'h0099_3CA5);

        // read with master NACK, status changes after capture
        status_in = 8'hC3;
        bus_start();
        send_byte(8'h13, a); push_check("R1 read address ack", {31'd0, a}, 32'd1);
        status_in = 8'h00;
        read_byte(1'b0, rb);
        push_check("R7 status MSB first and stable", {24'd0, rb}, 32'h0000_00C3);
        push_check("R8 NACK leaves registers", cmd_q, 32'h0099_3CA5);
        bus_start();
        wr_group(8'h07, 8'h42);
        bus_stop(); q();
        push_check("R8 new transfer after read and R3 alias", cmd_q, 32'h4299_3CA5);

        // read with master ACK
        status_in = 8'h5A;
        bus_start();
        send_byte(8'h13, a); push_check("R1 read address ack", {31'd0, a}, 32'd1);
        read_byte(1'b1, rb);
        push_check("R7 second status byte", {24'd0, rb}, 32'h0000_005A);
        bus_stop(); q();
        push_check("R8 ACK then STOP leaves registers", cmd_q, 32'h4299_3CA5);

        // clear discards staged data
        bus_start();
        wr_group(8'h00, 8'h77);
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
        push_check("R9 clear zeroes outputs", cmd_q, 32'h0);
        bus_stop(); q();
        push_check("R9 staged data lost on clear", cmd_q, 32'h0);

        // reset zeroes committed data
        bus_start();
        wr_group(8'h01, 8'h11);
        bus_stop(); q();
        push_check("R5 commit after clear", cmd_q, 32'h0000_1100);
        @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0; @(negedge clk);
        push_check("R9 reset zeroes outputs", cmd_q, 32'h0);

        push_check("R10 SDA drive moved with SCL high", r10_viol, 32'd0);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule